// File: doc/BRIEF.md
# Overlapping 1011 Serial Detector

This block watches a one-bit serial stream and samples it on every rising clock edge. It raises a one-bit flag when the four most recent samples, oldest first, read 1, 0, 1, 1. Detection is never restarted by a hit. The trailing bits of one occurrence can begin the next, so the stream 1011011 yields two flags.

The design is a five-state Moore machine built from three parts. A combinational next-state function looks at the present state and the current input. A state register has an asynchronous active-high reset. An output decoder looks at the present state alone. Each state records how much of the pattern has been seen:

- `ST_IDLE`: nothing useful yet.
- `ST_GOT1`: seen "1".
- `ST_GOT10`: seen "10".
- `ST_GOT101`: seen "101".
- `ST_MATCH`: seen "1011".

Only `ST_MATCH` drives the flag high. The transitions, written as (input 0 / input 1), are:

| State | On input 0 | On input 1 |
|---|---|---|
| `ST_IDLE` | `ST_IDLE` | `ST_GOT1` |
| `ST_GOT1` | `ST_GOT10` | `ST_GOT1` |
| `ST_GOT10` | `ST_IDLE` | `ST_GOT101` |
| `ST_GOT101` | `ST_GOT10` | `ST_MATCH` |
| `ST_MATCH` | `ST_GOT10` | `ST_GOT1` |

Any encoding outside these five states falls back to `ST_IDLE` on the next edge.

Top module: `overlap_pattern_det`

## Requirements
- R1: `hit` is 1 in a clock cycle exactly when the last four `din` values sampled since reset were 1, 0, 1, 1 (oldest first); otherwise it is 0.
- R2: Matches overlap. The sampled stream 1,0,1,1,0,1,1 gives `hit` = 0,0,0,1,0,0,1 in the cycles that follow each sample.
- R3: Each match produces a pulse of exactly one cycle, and `hit` is never high in two consecutive cycles.
- R4: While `rst` is 1, `hit` is 0 immediately, without waiting for a clock edge, and the machine is held in `ST_IDLE`.
- R5: A partial pattern seen before a reset is forgotten. After reset, a full 1,0,1,1 must be sampled before `hit` rises.
- R6: `hit` depends only on the present state. Changes on `din` between clock edges do not change `hit`.
- R7: State transitions follow the table above. In particular, repeated 1s keep `ST_GOT1`, so the stream 1,1,0,1,1 flags on its fifth sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial data bit |
| hit | output | 1 | High for one cycle after the pattern completes |

## Verification
A wrong state shows at `hit` within at most four samples. A state that has fallen behind drops or delays a pulse. A state that has run ahead produces a pulse whose preceding four inputs differ from 1011. A bad transition from `ST_MATCH` shows up most quickly as a missed overlapping second pulse, three samples after the first. Because the flag comes from state alone, any mismatch appears in the cycle right after the offending edge and never mid-cycle.

// File: rtl/det_pkg.sv
`timescale 1ns/1ps
package det_pkg;

    // Progress through the 1011 pattern, one state per prefix length.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GOT1   = 3'd1,
        ST_GOT10  = 3'd2,
        ST_GOT101 = 3'd3,
        ST_MATCH  = 3'd4
    } det_state_e;

endpackage

// File: rtl/det_next_state.sv
`timescale 1ns/1ps
module det_next_state
    import det_pkg::*;
(
    input  det_state_e state,
    input  logic       din,
    output det_state_e nxt
);

    always_comb begin
        unique case (state)
            ST_IDLE:   nxt = din ? ST_GOT1   : ST_IDLE;
            ST_GOT1:   nxt = din ? ST_GOT1   : ST_GOT10;
            ST_GOT10:  nxt = din ? ST_GOT101 : ST_IDLE;
            ST_GOT101: nxt = din ? ST_MATCH  : ST_GOT10;
            // Keep the overlapping suffix: "1" or "10".
            ST_MATCH:  nxt = din ? ST_GOT1   : ST_GOT10;
            default:   nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/det_state_reg.sv
`timescale 1ns/1ps
module det_state_reg
    import det_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  det_state_e nxt,
    output det_state_e state
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/det_output_decode.sv
`timescale 1ns/1ps
module det_output_decode
    import det_pkg::*;
(
    input  det_state_e state,
    output logic       hit
);

    always_comb begin
        unique case (state)
            ST_MATCH: hit = 1'b1;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/overlap_pattern_det.sv
`timescale 1ns/1ps
module overlap_pattern_det
    import det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    det_state_e state_q;
    det_state_e state_d;

    det_next_state u_next (
        .state (state_q),
        .din   (din),
        .nxt   (state_d)
    );

    det_state_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt   (state_d),
        .state (state_q)
    );

    det_output_decode u_dec (
        .state (state_q),
        .hit   (hit)
    );

endmodule

// File: rtl/det_checker.sv
`timescale 1ns/1ps
module det_checker
    import det_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       hit,
    input det_state_e state
);

    // R1
    pattern_seen_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(din, 1) && $past(din, 2) && !$past(din, 3) && $past(din, 4)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    // R7
    match_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MATCH) |=> (state == ST_GOT1 || state == ST_GOT10));

    // R7
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        state inside {ST_IDLE, ST_GOT1, ST_GOT10, ST_GOT101, ST_MATCH});

    // R4
    always @(negedge clk) begin
        if (rst) begin
            reset_quiet_chk: assert (!hit && state == ST_IDLE);
        end
    end

endmodule

bind overlap_pattern_det det_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit   (hit),
    .state (state_q)
);

// File: tb/overlap_pattern_det_bench.sv
`timescale 1ns/100ps
module overlap_pattern_det_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int checks = 0;
    int fails  = 0;

    // Reference: sliding window of the samples taken since reset.
    logic [3:0] hist  = 4'b0;
    int         count = 0;
    logic       prev_hit = 1'b0;

    overlap_pattern_det u_overlap_pattern_det (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: hit=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one bit, let it be sampled, then compare against the window.
    task automatic step(input logic b, input string tag);
        logic exp;
        din = b;
        @(posedge clk);
        hist  = {hist[2:0], b};
        count++;
        #1;
        exp = (count >= 4) && (hist == 4'b1011);
        chk(hit, exp, tag);
        if (hit && prev_hit) begin
            checks++;
            fails++;
            $display("FAIL R3: hit=1 expected=0 (two consecutive cycles) at %0t", $time);
        end
        prev_hit = hit;
    endtask

    task automatic do_reset();
        #0.5 rst = 1'b1;
        #0.5;
        hist = 4'b0;
        count = 0;
        prev_hit = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        chk(hit, 1'b0, "R4 reset state");
        do_reset();
        chk(hit, 1'b0, "R4 after release");
    endtask

    task automatic test_example();
        logic [6:0] s;
        s = 7'b1011011;
        for (int i = 6; i >= 0; i--) step(s[i], "R2 overlap example");
        do_reset();
    endtask

    task automatic test_self_loop();
        logic [4:0] s;
        s = 5'b11011;
        for (int i = 4; i >= 0; i--) step(s[i], "R7 repeated ones");
        step(1'b0, "R7 match exit on 0");
        step(1'b1, "R7 got101");
        step(1'b1, "R7 second match");
        step(1'b1, "R7 match exit on 1");
        step(1'b0, "R7 got10");
        step(1'b0, "R7 back to idle");
        step(1'b1, "R7 fresh start");
        do_reset();
    endtask

    task automatic test_reset_mid();
        step(1'b1, "R1 prefix");
        step(1'b0, "R1 prefix");
        step(1'b1, "R1 prefix");
        step(1'b1, "R1 full match");
        rst = 1'b1;
        #0.5;
        chk(hit, 1'b0, "R4 async reset clears hit");
        hist = 4'b0;
        count = 0;
        prev_hit = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        step(1'b1, "R5 partial");
        step(1'b0, "R5 partial");
        step(1'b1, "R5 partial");
        rst = 1'b1;
        #0.5;
        hist = 4'b0;
        count = 0;
        prev_hit = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        step(1'b1, "R5 no carry-over");
        step(1'b0, "R5 rebuild");
        step(1'b1, "R5 rebuild");
        step(1'b1, "R5 full pattern after reset");
        do_reset();
    endtask

    task automatic test_din_ignored();
        step(1'b1, "R6 setup");
        step(1'b0, "R6 setup");
        step(1'b1, "R6 setup");
        step(1'b1, "R6 setup match");
        for (int i = 0; i < 4; i++) begin
            #0.3 din = ~din;
            #0.1 chk(hit, 1'b1, "R6 din toggle mid-cycle");
        end
        step(1'b0, "R6 after toggles");
        do_reset();
    endtask

    task automatic test_random();
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 1)), "R1 random stream");
        end
        do_reset();
    endtask

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset_state();
        test_example();
        test_self_loop();
        test_reset_mid();
        test_din_ignored();
        test_random();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule